// File: doc/BRIEF.md
# Power-Management Event, Control and Timer Register Block

This block holds a small set of power-management registers on a simple register bus (byte address, four byte enables, 32-bit write data, combinational 32-bit read data). It contains a 16-bit event status register, a 16-bit event enable register, a 16-bit control register and a free-running power-management count that is 24 bits wide by default. The count advances by one on every clock cycle in which the `tick` strobe is high. The logic that generates the tick rate sits outside the block.

When the count rolls past its all-ones value, it returns to zero and a sticky overflow flag is set in the status register. If the overflow enable bit was set at that moment, the block raises a level interrupt request and clears the whole enable register. The interrupt therefore fires once, and software must enable it again before it can fire a second time. The request stays high until software clears the overflow flag by writing a one to it.

A separate global status flag is set by the `gblEvt` input and is cleared in the same write-one-to-clear way. Software requests power-off by writing the control register with the sleep-enable bit set and the sleep-type field set to all ones. This produces a one-cycle shutdown pulse and clears the count.

Top module: `pmEvtTimerRegs`

## Requirements
- R1: After reset the status register reads 0, the enable register reads 0, the control register reads 0x0001 (bit 0 set), the count reads 0, and `irqReq` and `shutdownReq` are low.
- R2: Register map, using byte addresses with bits 1:0 equal to 0:
  - Address 0x0 returns the enable register in bits 31:16 and the status register in bits 15:0.
  - Address 0x4 returns the control register in bits 15:0.
  - Address 0x8 returns the count in bits 23:0.
  - All other bits, address 0xC and any address with bits 1:0 nonzero read as 0.
  - Writes to address 0xC or to a misaligned address change nothing.
- R3: The count increases by one on each clock edge at which `tick` is high, and it holds when `tick` is low.
- R4: At a clock edge with `tick` high and the count at 0xFFFFFF, the count becomes 0 and status bit 0 (overflow flag) is set.
- R5: Status register writes are write-one-to-clear:
  - Writing a 1 to bit 0 or bit 5 through byte lane 0 at address 0x0 clears that bit.
  - Writing a 0 leaves the bit unchanged.
  - A cycle with `gblEvt` high sets bit 5.
  - All other status bits always read 0.
- R6: An overflow occurring while enable bit 0 is set raises `irqReq` at that same edge and clears the whole enable register. An overflow while enable bit 0 is clear does not raise `irqReq`.
- R7: `irqReq` stays high until a write clears status bit 0. It falls at the edge of that write.
- R8: Only byte lanes whose enable bit is set are written. At address 0x0, lanes 2 and 3 write enable bits 7:0 and 15:8. At address 0x4, lanes 0 and 1 write control bits 7:0 and 15:8. A write to a high byte leaves the low byte unchanged.
- R9: A control write through lane 1 with bit 13 set and bits 12:10 equal to 3'b111 pulses `shutdownReq` high for exactly the one cycle after the write, and clears the count at that edge. Any other sleep-type value produces no pulse.
- R10: A write at address 0x8 loads the count through byte lanes 0 to 2. Write data bits 31:24 are ignored. A load takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-advance strobe |
| gblEvt | input | 1 | Sets the global status flag |
| busWe | input | 1 | Write strobe for the current bus cycle |
| busAddr | input | 4 | Byte address within the block |
| busBe | input | 4 | Byte enables for the write lanes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| irqReq | output | 1 | Level interrupt request on an enabled overflow |
| shutdownReq | output | 1 | One-cycle power-off request |

## Verification
Every register, the count, `irqReq` and `shutdownReq` change at the same clock edge that samples the write, tick or event, so their new values can be seen one cycle after the stimulus. `shutdownReq` is the exception in duration: it is high only during the cycle immediately after the sleep write.

The bench applies inputs just after each falling edge. On every falling edge it compares the read data for the address currently driven, together with both request outputs, against a behavioural model that it updates on the rising edge. Directed checks read the registers on the falling edge that follows each stimulus. The single-cycle shutdown pulse is checked both in the cycle right after the write and in the cycle after that.

// File: rtl/pmEvtPkg.sv
package pmEvtPkg;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;
  localparam int BE_W   = BUS_W / 8;
  localparam int REG_W  = 16;

  // bit positions that software and neighbouring logic rely on
  localparam int OVF_BIT     = 0;
  localparam int GBL_BIT     = 5;
  localparam int SCI_BIT     = 0;
  localparam int SLP_EN_BIT  = 13;
  localparam int SLP_TYP_LSB = 10;
  localparam logic [2:0] SLP_TYP_OFF = 3'b111;

  // register select from address bits 3:2
  localparam logic [1:0] SEL_EVT = 2'd0;
  localparam logic [1:0] SEL_CTL = 2'd1;
  localparam logic [1:0] SEL_TMR = 2'd2;

  localparam logic [REG_W-1:0] CTL_RESET = REG_W'(1) << SCI_BIT;

  // strobes from control to datapath
  typedef struct packed {
    logic enLo;
    logic enHi;
    logic ctlLo;
    logic ctlHi;
    logic tmrWr;
    logic clrOvf;
    logic clrGbl;
    logic sleepCmd;
    logic fire;
  } pmStrobes_t;
endpackage

// File: rtl/pmEvtCtrl.sv
module pmEvtCtrl
  import pmEvtPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BE_W-1:0]   busBe,
  input  logic [1:0]        clrBits,    // {global, overflow} bits of the write data
  input  logic [3:0]        sleepBits,  // {sleep enable, sleep type}
  input  logic              wrapNow,
  input  logic              ovfArmed,
  output pmStrobes_t        strb,
  output logic              irqReq,
  output logic              shutdownReq
);
  logic aligned;
  logic wrEvt, wrCtl, wrTmr;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wrEvt   = busWe && aligned && (busAddr[3:2] == SEL_EVT);
  assign wrCtl   = busWe && aligned && (busAddr[3:2] == SEL_CTL);
  assign wrTmr   = busWe && aligned && (busAddr[3:2] == SEL_TMR);

  always_comb begin
    strb          = '0;
    strb.enLo     = wrEvt && busBe[2];
    strb.enHi     = wrEvt && busBe[3];
    strb.ctlLo    = wrCtl && busBe[0];
    strb.ctlHi    = wrCtl && busBe[1];
    strb.tmrWr    = wrTmr;
    strb.clrOvf   = wrEvt && busBe[0] && clrBits[0];
    strb.clrGbl   = wrEvt && busBe[0] && clrBits[1];
    strb.sleepCmd = wrCtl && busBe[1] && sleepBits[3] && (sleepBits[2:0] == SLP_TYP_OFF);
    strb.fire     = wrapNow && ovfArmed;
  end

  // interrupt latch: armed by an enabled overflow, released by clearing the flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq      <= 1'b0;
      shutdownReq <= 1'b0;
    end else begin
      if (strb.fire)        irqReq <= 1'b1;
      else if (strb.clrOvf) irqReq <= 1'b0;
      shutdownReq <= strb.sleepCmd;
    end
  end
endmodule

// File: rtl/pmEvtDatapath.sv
module pmEvtDatapath
  import pmEvtPkg::*;
#(
  parameter int TIMER_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               gblEvt,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BE_W-1:0]    busBe,
  input  logic [BUS_W-1:0]   busWdata,
  input  pmStrobes_t         strb,
  output logic               wrapNow,
  output logic               ovfArmed,
  output logic [REG_W-1:0]   statusQ,
  output logic [REG_W-1:0]   enableQ,
  output logic [TIMER_W-1:0] timerQ,
  output logic [BUS_W-1:0]   busRdata
);
  localparam int TMR_LANES = (TIMER_W + 7) / 8;
  localparam int EXT_W     = 8 * TMR_LANES;

  logic [REG_W-1:0]   controlQ;
  logic [REG_W-1:0]   statusNext, enableNext, controlNext;
  logic [TIMER_W-1:0] timerNext;
  logic [EXT_W-1:0]   timerExt, timerMerged;

  assign wrapNow  = tick && (&timerQ);
  assign ovfArmed = enableQ[OVF_BIT];
  assign timerExt = EXT_W'(timerQ);

  // byte-lane merge for count loads
  for (genvar k = 0; k < TMR_LANES; k++) begin : gTmrLane
    assign timerMerged[8*k +: 8] = busBe[k] ? busWdata[8*k +: 8] : timerExt[8*k +: 8];
  end

  always_comb begin
    statusNext          = '0;
    statusNext[OVF_BIT] = wrapNow || (statusQ[OVF_BIT] && !strb.clrOvf);
    statusNext[GBL_BIT] = gblEvt  || (statusQ[GBL_BIT] && !strb.clrGbl);
  end

  always_comb begin
    enableNext = enableQ;
    if (strb.enLo) enableNext[7:0]  = busWdata[23:16];
    if (strb.enHi) enableNext[15:8] = busWdata[31:24];
    if (strb.fire) enableNext = '0;
  end

  always_comb begin
    controlNext = controlQ;
    if (strb.ctlLo) controlNext[7:0]  = busWdata[7:0];
    if (strb.ctlHi) controlNext[15:8] = busWdata[15:8];
  end

  always_comb begin
    if (strb.tmrWr)         timerNext = timerMerged[TIMER_W-1:0];
    else if (strb.sleepCmd) timerNext = '0;
    else if (tick)          timerNext = timerQ + TIMER_W'(1);
    else                    timerNext = timerQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      enableQ  <= '0;
      controlQ <= CTL_RESET;
      timerQ   <= '0;
    end else begin
      statusQ  <= statusNext;
      enableQ  <= enableNext;
      controlQ <= controlNext;
      timerQ   <= timerNext;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr[1:0] == 2'b00) begin
      case (busAddr[3:2])
        SEL_EVT: busRdata = {enableQ, statusQ};
        SEL_CTL: busRdata = BUS_W'(controlQ);
        SEL_TMR: busRdata = BUS_W'(timerQ);
        default: busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pmEvtTimerRegs.sv
module pmEvtTimerRegs
  import pmEvtPkg::*;
#(
  parameter int TIMER_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              gblEvt,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BE_W-1:0]   busBe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irqReq,
  output logic              shutdownReq
);
  pmStrobes_t         strb;
  logic               wrapNow, ovfArmed;
  logic [REG_W-1:0]   statusQ, enableQ;
  logic [TIMER_W-1:0] timerQ;

  pmEvtCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWe      (busWe),
    .busAddr    (busAddr),
    .busBe      (busBe),
    .clrBits    ({busWdata[GBL_BIT], busWdata[OVF_BIT]}),
    .sleepBits  (busWdata[SLP_EN_BIT:SLP_TYP_LSB]),
    .wrapNow    (wrapNow),
    .ovfArmed   (ovfArmed),
    .strb       (strb),
    .irqReq     (irqReq),
    .shutdownReq(shutdownReq)
  );

  pmEvtDatapath #(.TIMER_W(TIMER_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .gblEvt  (gblEvt),
    .busAddr (busAddr),
    .busBe   (busBe),
    .busWdata(busWdata),
    .strb    (strb),
    .wrapNow (wrapNow),
    .ovfArmed(ovfArmed),
    .statusQ (statusQ),
    .enableQ (enableQ),
    .timerQ  (timerQ),
    .busRdata(busRdata)
  );
endmodule

// File: rtl/pmEvtChecker.sv
module pmEvtChecker #(
  parameter int TIMER_W = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               tick,
  input logic               busWe,
  input logic [3:0]         busAddr,
  input logic [1:0]         beLow,
  input logic               wdOvf,
  input logic [3:0]         wdSleep,
  input logic               irqReq,
  input logic               shutdownReq,
  input logic [15:0]        statusQ,
  input logic [15:0]        enableQ,
  input logic [TIMER_W-1:0] timerQ
);
  // R7: the request never stands without the overflow flag
  assert_irq_has_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> statusQ[0]);

  // R6: a new request comes from an armed enable, and the enable is emptied
  assert_fire_empties_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> (enableQ == 16'h0) && $past(enableQ[0]));

  // R7: the request only drops after a clearing write
  assert_irq_drop_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqReq) |-> $past(busWe && busAddr == 4'h0 && beLow[0] && wdOvf));

  // R9: pulse only after a power-off write, and the count is zero then
  assert_shutdown_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(busWe && busAddr == 4'h4 && beLow[1] && wdSleep == 4'b1111));

  assert_shutdown_zero_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> (timerQ == '0));

  // R4: the flag rises together with the wrap to zero
  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statusQ[0]) && !$past(busWe)) |-> (timerQ == '0));

  // R3: no tick and no write keeps the count
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(tick) && !$past(busWe)) |-> $stable(timerQ));

  // R5: only the two flags exist in the status register
  assert_status_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & 16'hFFDE) == 16'h0);
endmodule

bind pmEvtTimerRegs pmEvtChecker #(.TIMER_W(TIMER_W)) i_pmEvtChecker (
  .clk        (clk),
  .rstN       (rstN),
  .tick       (tick),
  .busWe      (busWe),
  .busAddr    (busAddr),
  .beLow      (busBe[1:0]),
  .wdOvf      (busWdata[0]),
  .wdSleep    (busWdata[13:10]),
  .irqReq     (irqReq),
  .shutdownReq(shutdownReq),
  .statusQ    (statusQ),
  .enableQ    (enableQ),
  .timerQ     (timerQ)
);

// File: tb/test_pmEvtTimerRegs.sv
module test_pmEvtTimerRegs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        gblEvt = 1'b0;
  logic        busWe = 1'b0;
  logic [3:0]  busAddr = 4'h0;
  logic [3:0]  busBe = 4'h0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        irqReq, shutdownReq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmEvtTimerRegs i_pmEvtTimerRegs (
    .clk(clk), .rstN(rstN), .tick(tick), .gblEvt(gblEvt), .busWe(busWe),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata),
    .irqReq(irqReq), .shutdownReq(shutdownReq)
  );

  // behavioural reference model
  logic [15:0] mSts = 16'h0, mEn = 16'h0, mCtl = 16'h0001;
  logic [23:0] mTmr = 24'h0;
  logic        mIrq = 1'b0, mShut = 1'b0;

  function automatic logic [31:0] mRead(input logic [3:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[3:2])
      2'd0: return {mEn, mSts};
      2'd1: return {16'h0, mCtl};
      2'd2: return {8'h0, mTmr};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSts = 0; mEn = 0; mCtl = 16'h0001; mTmr = 0; mIrq = 0; mShut = 0;
    end else begin
      bit wrap, fire, clrO, clrG, sleep;
      wrap  = tick && (mTmr == 24'hFFFFFF);
      fire  = wrap && mEn[0];
      clrO  = busWe && busAddr == 4'h0 && busBe[0] && busWdata[0];
      clrG  = busWe && busAddr == 4'h0 && busBe[0] && busWdata[5];
      sleep = busWe && busAddr == 4'h4 && busBe[1] && busWdata[13:10] == 4'hF;
      mSts[0] = wrap || (mSts[0] && !clrO);
      mSts[5] = gblEvt || (mSts[5] && !clrG);
      if (busWe && busAddr == 4'h0) begin
        if (busBe[2]) mEn[7:0]  = busWdata[23:16];
        if (busBe[3]) mEn[15:8] = busWdata[31:24];
      end
      if (fire) mEn = 0;
      if (busWe && busAddr == 4'h4) begin
        if (busBe[0]) mCtl[7:0]  = busWdata[7:0];
        if (busBe[1]) mCtl[15:8] = busWdata[15:8];
      end
      if (busWe && busAddr == 4'h8) begin
        for (int k = 0; k < 3; k++) if (busBe[k]) mTmr[8*k +: 8] = busWdata[8*k +: 8];
      end else if (sleep) mTmr = 0;
      else if (tick) mTmr = mTmr + 24'd1;
      if (fire) mIrq = 1; else if (clrO) mIrq = 0;
      mShut = sleep;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (!done) begin
    check("R2 model read", busRdata, mRead(busAddr));
    check("R7 model irq", {31'h0, irqReq}, {31'h0, mIrq});
    check("R9 model shutdown", {31'h0, shutdownReq}, {31'h0, mShut});
  end

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d, input bit tk);
    @(negedge clk); #1;
    busWe = 1; busAddr = a; busBe = be; busWdata = d; tick = tk;
    @(negedge clk); #1;
    busWe = 0; busBe = 0; busWdata = 0; tick = 0;
  endtask

  task automatic rdChk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk); #1;
    busAddr = a;
    #1 check(req, busRdata, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); #1 tick = 1;
    repeat (n) @(negedge clk);
    #1 tick = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    // R1: reset values
    check("R1 irq", {31'h0, irqReq}, 32'h0);
    check("R1 shutdown", {31'h0, shutdownReq}, 32'h0);
    rdChk("R1 event regs", 4'h0, 32'h0);
    rdChk("R1 control", 4'h4, 32'h0000_0001);
    rdChk("R1 count", 4'h8, 32'h0);

    // R2/R8: enable in upper half, lane writes
    wr(4'h0, 4'b1100, 32'hABCD_0000, 0);
    rdChk("R2 enable upper half", 4'h0, 32'hABCD_0000);
    wr(4'h0, 4'b1000, 32'h1200_0000, 0);
    rdChk("R8 enable high byte", 4'h0, 32'h12CD_0000);
    wr(4'h4, 4'b0011, 32'hFFFF_0004, 0);
    rdChk("R2 control low half", 4'h4, 32'h0000_0004);
    wr(4'h4, 4'b0010, 32'h0000_5A00, 0);
    rdChk("R8 control high byte", 4'h4, 32'h0000_5A04);
    wr(4'hC, 4'b1111, 32'hFFFF_FFFF, 0);
    wr(4'h2, 4'b1111, 32'hFFFF_FFFF, 0);
    rdChk("R2 ignored writes", 4'h0, 32'h12CD_0000);
    rdChk("R2 address 0xC", 4'hC, 32'h0);
    rdChk("R2 misaligned", 4'h2, 32'h0);

    // R3/R10: count load and ticking
    wr(4'h8, 4'b0111, 32'h0000_0010, 0);
    ticks(5);
    rdChk("R3 five ticks", 4'h8, 32'h0000_0015);
    wr(4'h8, 4'b1111, 32'hFF00_0100, 1);
    rdChk("R10 load beats tick", 4'h8, 32'h0000_0100);

    // R4: wrap without enable
    wr(4'h0, 4'b1100, 32'h0, 0);
    wr(4'h8, 4'b0111, 32'h00FF_FFFE, 0);
    ticks(2);
    check("R6 no irq when disabled", {31'h0, irqReq}, 32'h0);
    rdChk("R4 wrap sets flag", 4'h0, 32'h0000_0001);
    rdChk("R4 count wrapped", 4'h8, 32'h0);

    // R5: write-one-to-clear
    wr(4'h0, 4'b0001, 32'h0, 0);
    rdChk("R5 zero write keeps", 4'h0, 32'h0000_0001);
    @(negedge clk); #1 gblEvt = 1;
    @(negedge clk); #1 gblEvt = 0;
    rdChk("R5 global set", 4'h0, 32'h0000_0021);
    wr(4'h0, 4'b0001, 32'h0000_0020, 0);
    rdChk("R5 global cleared", 4'h0, 32'h0000_0001);
    wr(4'h0, 4'b0001, 32'h0000_0001, 0);
    rdChk("R5 overflow cleared", 4'h0, 32'h0);

    // R6/R7: one-shot interrupt
    wr(4'h0, 4'b0100, 32'h0001_0000, 0);
    wr(4'h8, 4'b0111, 32'h00FF_FFFF, 0);
    ticks(1);
    check("R6 irq raised", {31'h0, irqReq}, 32'h1);
    rdChk("R6 enable emptied", 4'h0, 32'h0000_0001);
    repeat (3) @(negedge clk);
    check("R7 irq held", {31'h0, irqReq}, 32'h1);
    wr(4'h0, 4'b0001, 32'h0, 0);
    check("R7 zero write keeps irq", {31'h0, irqReq}, 32'h1);
    wr(4'h0, 4'b0001, 32'h1, 0);
    check("R7 irq dropped", {31'h0, irqReq}, 32'h0);
    wr(4'h8, 4'b0111, 32'h00FF_FFFF, 0);
    ticks(1);
    check("R6 no second fire", {31'h0, irqReq}, 32'h0);
    wr(4'h0, 4'b0001, 32'h1, 0);

    // R9: power-off command
    wr(4'h8, 4'b0111, 32'h0000_1234, 0);
    wr(4'h4, 4'b0011, 32'h0000_3801, 0);
    check("R9 other type no pulse", {31'h0, shutdownReq}, 32'h0);
    rdChk("R9 count kept", 4'h8, 32'h0000_1234);
    wr(4'h4, 4'b0011, 32'h0000_3C01, 0);
    check("R9 pulse high", {31'h0, shutdownReq}, 32'h1);
    @(negedge clk); #1;
    check("R9 pulse one cycle", {31'h0, shutdownReq}, 32'h0);
    rdChk("R9 count cleared", 4'h8, 32'h0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule